// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a cycle-accurate behavioural model of a flow-through synchronous burst static RAM. On every rising clock edge it classifies the sampled control inputs as a deselect, a new read, a new write, a burst advance, a burst hold, or an idle cycle. It keeps a two-bit burst counter that walks a four-word group in either linear or interleaved order. Byte-lane write strobes are applied to a small internal array.

Two address strobes start new accesses. The processor-side strobe always starts a read and is ignored outright when the primary select is high. The controller-side strobe starts a read or a write and deselects the device when any select is inactive. After an access starts, a cycle with both strobes high continues the burst. In that cycle the advance input picks between the next and the current address, and the write inputs sampled in that cycle pick read or write. Read data flows straight from the array at the registered address, with no output register. Data is presented only while output enable is low. An asynchronous sleep input silences the device and leaves the array contents intact.

Top module: `sburst_sram`

## Requirements
- R1: Chip enable means `sel1_n`=0, `sel2`=1 and `sel3_n`=0 at the edge where a strobe is sampled. A controller strobe (`adsc_n`=0, `adsp_n`=1) without chip enable deselects the device. A processor strobe with `sel1_n`=0 but `sel2`=0 or `sel3_n`=1 also deselects it. A continue cycle while deselected keeps it deselected.
- R2: A processor strobe with `sel1_n`=1 is ignored. If `adsc_n` is high in that cycle, the burst in progress continues as if no strobe had been seen.
- R3: A processor strobe with chip enable starts a read at `addr`, whatever the write inputs are. It takes priority over a controller strobe in the same cycle.
- R4: A controller strobe with chip enable starts a write at `addr` when a write is requested, and a read otherwise. A write is requested when `gwr_n`=0, or when `wr_n`=0 and at least one `ben_n` bit is 0.
- R5: When `gwr_n`=0, every byte lane is written. Otherwise lane i (bits 8i+7..8i of `dq_d`) is written only when `wr_n`=0 and `ben_n[i]`=0. Lanes that are not written keep their old contents.
- R6: With both strobes high and the device selected, `adv_n`=0 moves to the next burst address and `adv_n`=1 stays on the current one. That beat is a write when the write inputs request one and a read otherwise.
- R7: With `order_il`=0 the low two address bits go start, start+1, start+2, start+3 modulo 4. The fifth beat wraps back to the start. The upper bits never change within a burst.
- R8: With `order_il`=1 the low two address bits of beat n are start XOR n.
- R9: `dq_oe` is 1 only in a read cycle of a selected device with `oe_n`=0 and `sleep`=0. `oe_n` acts without waiting for a clock. During such a cycle `dq_q` holds the array word at the address registered on the edge that began the cycle.
- R10: While `sleep`=1, `dq_oe` is 0 at once and every clocked input is ignored. The array keeps its contents. After `sleep` falls, the device stays deselected until a strobe starts a new access.
- R11: Synchronous reset (`rst`=1) leaves the device deselected, with `dq_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every control is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address; the low two bits start the burst |
| adsp_n | input | 1 | Processor-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Primary chip select, active low |
| sel2 | input | 1 | Expansion chip select, active high |
| sel3_n | input | 1 | Expansion chip select, active low |
| gwr_n | input | 1 | Global write, all lanes, active low |
| wr_n | input | 1 | Lane write qualifier, active low |
| ben_n | input | NB | Per-lane byte enables, active low |
| dq_d | input | NB*8 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_il | input | 1 | Burst order, static: 0 linear, 1 interleaved |
| sleep | input | 1 | Asynchronous sleep, active high |
| dq_q | output | NB*8 | Read data, flow-through from the array |
| dq_oe | output | 1 | High when `dq_q` would be driven onto the bus |

## Verification
A corrupted burst counter or latched start offset shows up on the next advance beat: `dq_q` returns a neighbouring word of the four-word group in the same cycle. A wrong select or active flag shows as `dq_oe` going high or low one cycle after the strobe that should have set it. Lane-mask faults stay hidden until the word is read back, so every masked write is followed directly by a read of the same address, and the result is compared with a reference memory. Sleep faults show either at once on `dq_oe` or on the first continue cycle after release.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Classification of one sampled clock cycle
    typedef enum logic [2:0] {
        CYC_IDLE    = 3'd0,
        CYC_DESEL   = 3'd1,
        CYC_RD_NEW  = 3'd2,
        CYC_WR_NEW  = 3'd3,
        CYC_ADVANCE = 3'd4,
        CYC_HOLD    = 3'd5
    } cyc_e;

    typedef struct packed {
        cyc_e kind;
        logic is_wr;
    } cyc_t;

    // Low address bits of beat n for a burst beginning at offset start
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] n,
                                               input logic       il);
        return il ? (start ^ n) : (start + n);
    endfunction

endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
    import sbs_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          adv_n,
    input  logic          sel1_n,
    input  logic          sel2,
    input  logic          sel3_n,
    input  logic          gwr_n,
    input  logic          wr_n,
    input  logic [NB-1:0] ben_n,
    input  logic          live,
    output cyc_t          cyc,
    output logic [NB-1:0] lane_we
);
    logic          chip_en;
    logic [NB-1:0] lane_req;
    logic          wr_req;

    assign chip_en  = !sel1_n && sel2 && !sel3_n;
    assign lane_req = {NB{!gwr_n}} | ({NB{!wr_n}} & ~ben_n);
    assign wr_req   = |lane_req;

    always_comb begin
        cyc.kind  = CYC_IDLE;
        cyc.is_wr = 1'b0;
        if (!adsp_n && !sel1_n) begin
            // processor strobe: read only
            cyc.kind = chip_en ? CYC_RD_NEW : CYC_DESEL;
        end else if (!adsc_n) begin
            if (!chip_en) begin
                cyc.kind = CYC_DESEL;
            end else begin
                cyc.kind  = wr_req ? CYC_WR_NEW : CYC_RD_NEW;
                cyc.is_wr = wr_req;
            end
        end else if (live) begin
            cyc.kind  = adv_n ? CYC_HOLD : CYC_ADVANCE;
            cyc.is_wr = wr_req;
        end
    end

    assign lane_we = lane_req & {NB{cyc.is_wr}};

endmodule

// File: rtl/sbs_burst.sv
module sbs_burst
    import sbs_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          freeze,
    input  cyc_t          cyc,
    input  logic [AW-1:0] ext_addr,
    input  logic          order_il,
    output logic [AW-1:0] beat_addr,
    output logic [AW-1:0] cur_addr,
    output logic          live,
    output logic          rd_q
);
    localparam int HW = AW - 2;

    logic [HW-1:0] hi_q, hi_n;
    logic [1:0]    st_q, st_n, cnt_q, cnt_n;
    logic          live_n, rd_n;

    always_comb begin
        hi_n   = hi_q;
        st_n   = st_q;
        cnt_n  = cnt_q;
        live_n = live;
        rd_n   = rd_q;
        unique case (cyc.kind)
            CYC_RD_NEW, CYC_WR_NEW: begin
                hi_n   = ext_addr[AW-1:2];
                st_n   = ext_addr[1:0];
                cnt_n  = 2'd0;
                live_n = 1'b1;
                rd_n   = !cyc.is_wr;
            end
            CYC_ADVANCE: begin
                cnt_n = cnt_q + 2'd1;
                rd_n  = !cyc.is_wr;
            end
            CYC_HOLD:  rd_n   = !cyc.is_wr;
            CYC_DESEL: live_n = 1'b0;
            default: ;
        endcase
    end

    assign beat_addr = {hi_n, beat_offset(st_n, cnt_n, order_il)};

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q     <= '0;
            st_q     <= '0;
            cnt_q    <= '0;
            live     <= 1'b0;
            rd_q     <= 1'b0;
            cur_addr <= '0;
        end else if (freeze) begin
            live <= 1'b0;
        end else begin
            hi_q     <= hi_n;
            st_q     <= st_n;
            cnt_q    <= cnt_n;
            live     <= live_n;
            rd_q     <= rd_n;
            cur_addr <= beat_addr;
        end
    end

endmodule

// File: rtl/sbs_lane_ram.sv
module sbs_lane_ram #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic [NB-1:0]    we,
    input  logic [AW-1:0]    waddr,
    input  logic [NB*BW-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [NB*BW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [BW-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we[g]) mem[waddr] <= wdata[g*BW +: BW];
        end
        assign rdata[g*BW +: BW] = mem[raddr];
    end

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
    import sbs_pkg::*;
#(
    parameter int AW = 6,
    parameter int NB = 4,
    localparam int DW = NB * 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          adv_n,
    input  logic          sel1_n,
    input  logic          sel2,
    input  logic          sel3_n,
    input  logic          gwr_n,
    input  logic          wr_n,
    input  logic [NB-1:0] ben_n,
    input  logic [DW-1:0] dq_d,
    input  logic          oe_n,
    input  logic          order_il,
    input  logic          sleep,
    output logic [DW-1:0] dq_q,
    output logic          dq_oe
);
    cyc_t          cyc;
    logic [NB-1:0] lane_req_we, lane_we;
    logic [AW-1:0] beat_addr, cur_addr;
    logic          live, rd_q;

    sbs_decode #(.NB(NB)) u_dec (
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .gwr_n(gwr_n), .wr_n(wr_n), .ben_n(ben_n),
        .live(live), .cyc(cyc), .lane_we(lane_req_we)
    );

    sbs_burst #(.AW(AW)) u_bst (
        .clk(clk), .rst(rst), .freeze(sleep), .cyc(cyc),
        .ext_addr(addr), .order_il(order_il),
        .beat_addr(beat_addr), .cur_addr(cur_addr),
        .live(live), .rd_q(rd_q)
    );

    assign lane_we = (sleep || rst) ? '0 : lane_req_we;

    sbs_lane_ram #(.AW(AW), .NB(NB), .BW(8)) u_ram (
        .clk(clk), .we(lane_we), .waddr(beat_addr), .wdata(dq_d),
        .raddr(cur_addr), .rdata(dq_q)
    );

    assign dq_oe = live && rd_q && !oe_n && !sleep;

endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          adsp_n,
    input logic          adsc_n,
    input logic          adv_n,
    input logic          sel1_n,
    input logic          sel2,
    input logic          sel3_n,
    input logic          gwr_n,
    input logic          wr_n,
    input logic          oe_n,
    input logic          sleep,
    input logic [DW-1:0] dq_q,
    input logic          dq_oe
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !dq_oe); // R11

    AST_CTRL_DESEL: assert property (@(posedge clk) disable iff (rst)
        (!sleep && adsp_n && !adsc_n && (sel1_n || !sel2 || sel3_n)) |=> !dq_oe); // R1

    AST_PROC_DESEL: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !adsp_n && !sel1_n && (!sel2 || sel3_n)) |=> !dq_oe); // R1

    AST_PROC_READ: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !adsp_n && !sel1_n && sel2 && !sel3_n) |=> (dq_oe || oe_n || sleep)); // R3

    AST_IGNORED_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !adsp_n && sel1_n && adsc_n && adv_n && gwr_n && wr_n) |=> $stable(dq_q)); // R2

    AST_CTRL_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!sleep && adsp_n && !adsc_n && !sel1_n && sel2 && !sel3_n && !gwr_n) |=> !dq_oe); // R4

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dq_oe); // R10

    AST_OE_GATES: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe); // R9

endmodule

bind sburst_sram sbs_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
    .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .gwr_n(gwr_n), .wr_n(wr_n),
    .oe_n(oe_n), .sleep(sleep), .dq_q(dq_q), .dq_oe(dq_oe)
);

// File: tb/sburst_sram_tb.sv
module sburst_sram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = NB * 8;

    typedef struct packed {
        logic [3:0] rq;
        logic       pn, cn, vn, s1n, s2, s3n, gwn, wn;
        logic [3:0] ben;
        logic       oen, il, slp;
        logic [5:0] ad;
        logic       drv;
    } vec_t;

    localparam int NV = 31;
    //                rq    pn cn vn s1 s2 s3 gw wn ben  oe il sl addr drv
    localparam vec_t TBL [NV] = '{
        '{4'd4, 1,0,1,0,1,0,0,1,4'hF,1,0,0,6'd12,0}, // R4 write 12
        '{4'd6, 1,1,0,0,1,0,0,1,4'hF,1,0,0,6'd0, 0}, // R6 write 13
        '{4'd6, 1,1,0,0,1,0,0,1,4'hF,1,0,0,6'd0, 0}, // R6 write 14
        '{4'd6, 1,1,0,0,1,0,0,1,4'hF,1,0,0,6'd0, 0}, // R6 write 15
        '{4'd4, 1,0,1,0,1,0,0,1,4'hF,1,0,0,6'd8, 0}, // R4 write 8
        '{4'd6, 1,1,0,0,1,0,0,1,4'hF,1,0,0,6'd0, 0}, // R6 write 9
        '{4'd6, 1,1,0,0,1,0,0,1,4'hF,1,0,0,6'd0, 0}, // R6 write 10
        '{4'd6, 1,1,0,0,1,0,0,1,4'hF,1,0,0,6'd0, 0}, // R6 write 11
        '{4'd7, 1,1,0,0,1,0,1,1,4'hF,0,0,0,6'd0, 1}, // R7 wrap read 8
        '{4'd3, 0,1,1,0,1,0,0,1,4'hF,0,0,0,6'd10,1}, // R3 read 10 despite gw
        '{4'd7, 1,1,0,0,1,0,1,1,4'hF,0,0,0,6'd0, 1}, // R7 11
        '{4'd7, 1,1,0,0,1,0,1,1,4'hF,0,0,0,6'd0, 1}, // R7 8
        '{4'd6, 1,1,1,0,1,0,1,1,4'hF,0,0,0,6'd0, 1}, // R6 hold 8
        '{4'd9, 1,1,1,0,1,0,1,1,4'hF,1,0,0,6'd0, 0}, // R9 oe high
        '{4'd2, 0,1,1,1,1,0,1,1,4'hF,0,0,0,6'd40,1}, // R2 ignored, still 8
        '{4'd1, 1,0,1,0,0,0,1,1,4'hF,0,0,0,6'd0, 0}, // R1 ctrl deselect
        '{4'd1, 0,1,1,0,1,1,1,1,4'hF,0,0,0,6'd0, 0}, // R1 proc deselect
        '{4'd1, 1,1,0,0,1,0,1,1,4'hF,0,0,0,6'd0, 0}, // R1 stays deselected
        '{4'd8, 0,1,1,0,1,0,1,1,4'hF,0,1,0,6'd10,1}, // R8 read 10
        '{4'd8, 1,1,0,0,1,0,1,1,4'hF,0,1,0,6'd0, 1}, // R8 11
        '{4'd8, 1,1,0,0,1,0,1,1,4'hF,0,1,0,6'd0, 1}, // R8 8
        '{4'd8, 1,1,0,0,1,0,1,1,4'hF,0,1,0,6'd0, 1}, // R8 9
        '{4'd5, 1,0,1,0,1,0,1,0,4'hA,0,0,0,6'd12,0}, // R5 lanes 0,2 to 12
        '{4'd5, 1,0,1,0,1,0,1,1,4'hF,0,0,0,6'd12,1}, // R5 read back 12
        '{4'd4, 1,0,1,0,1,0,1,0,4'hF,0,0,0,6'd13,1}, // R4 no lane -> read
        '{4'd5, 1,0,1,0,1,0,0,1,4'hF,0,0,0,6'd13,0}, // R5 global write 13
        '{4'd5, 1,0,1,0,1,0,1,1,4'hF,0,0,0,6'd13,1}, // R5 read back 13
        '{4'd5, 1,0,1,0,1,0,1,0,4'h0,0,0,0,6'd14,0}, // R5 all lanes 14
        '{4'd5, 1,0,1,0,1,0,1,1,4'hF,0,0,0,6'd14,1}, // R5 read back 14
        '{4'd6, 1,1,1,0,1,0,1,0,4'hE,0,0,0,6'd0, 0}, // R6 hold write lane0
        '{4'd6, 1,1,1,0,1,0,1,1,4'hF,0,0,0,6'd0, 1}  // R6 hold read 14
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic          sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
    logic          gwr_n = 1'b1, wr_n = 1'b1;
    logic [NB-1:0] ben_n = '1;
    logic [DW-1:0] dq_d = '0;
    logic          oe_n = 1'b1, order_il = 1'b0, sleep = 1'b0;
    logic [DW-1:0] dq_q;
    logic          dq_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state
    logic [DW-1:0] ref_mem [1<<AW];
    logic [AW-3:0] r_hi = '0;
    logic [1:0]    r_st = '0, r_cnt = '0;
    logic          r_live = 1'b0, r_rd = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sburst_sram #(.AW(AW), .NB(NB)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
        .gwr_n(gwr_n), .wr_n(wr_n), .ben_n(ben_n), .dq_d(dq_d), .oe_n(oe_n),
        .order_il(order_il), .sleep(sleep), .dq_q(dq_q), .dq_oe(dq_oe)
    );

    function automatic string rname(input logic [3:0] c);
        case (c)
            4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
            4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
            4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
            4'd10: return "R10"; default: return "R11";
        endcase
    endfunction

    function automatic logic [AW-1:0] ref_addr();
        logic [1:0] lo;
        lo = order_il ? (r_st ^ r_cnt) : (r_st + r_cnt);
        return {r_hi, lo};
    endfunction

    // reference update from the requirements, applied at a clock edge
    task automatic ref_step();
        logic          en, wreq;
        logic [NB-1:0] lanes;
        logic [AW-1:0] a;
        logic          do_wr;
        en    = !sel1_n && sel2 && !sel3_n;
        lanes = {NB{!gwr_n}} | ({NB{!wr_n}} & ~ben_n);
        wreq  = |lanes;
        do_wr = 1'b0;
        if (sleep) begin
            r_live = 1'b0;
        end else if (!adsp_n && !sel1_n) begin
            r_live = en;
            if (en) begin r_hi = addr[AW-1:2]; r_st = addr[1:0]; r_cnt = 0; r_rd = 1; end
        end else if (!adsc_n) begin
            r_live = en;
            if (en) begin
                r_hi = addr[AW-1:2]; r_st = addr[1:0]; r_cnt = 0;
                r_rd = !wreq; do_wr = wreq;
            end
        end else if (r_live) begin
            if (!adv_n) r_cnt = r_cnt + 2'd1;
            r_rd = !wreq; do_wr = wreq;
        end
        if (do_wr) begin
            a = ref_addr();
            for (int i = 0; i < NB; i++)
                if (lanes[i]) ref_mem[a][i*8 +: 8] = dq_d[i*8 +: 8];
        end
    endtask

    task automatic check_oe(input string tag, input logic exp);
        n_chk++;
        if (dq_oe !== exp) begin
            n_fail++;
            $display("FAIL %s dq_oe actual %b expected %b", tag, dq_oe, exp);
        end
    endtask

    task automatic check_data(input string tag);
        n_chk++;
        if (dq_q !== ref_mem[ref_addr()]) begin
            n_fail++;
            $display("FAIL %s dq_q actual %h expected %h", tag, dq_q, ref_mem[ref_addr()]);
        end
    endtask

    task automatic apply(input vec_t v, input logic [DW-1:0] d);
        adsp_n = v.pn; adsc_n = v.cn; adv_n = v.vn;
        sel1_n = v.s1n; sel2 = v.s2; sel3_n = v.s3n;
        gwr_n = v.gwn; wr_n = v.wn; ben_n = v.ben;
        oe_n = v.oen; order_il = v.il; sleep = v.slp; addr = v.ad; dq_d = d;
    endtask

    task automatic run_cycle(input vec_t v, input logic [DW-1:0] d);
        apply(v, d);
        @(posedge clk);
        ref_step();
        @(negedge clk);
        check_oe(rname(v.rq), v.drv);
        if (v.drv) check_data(rname(v.rq));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        check_oe("R11", 1'b0);               // R11 deselected under reset
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            run_cycle(TBL[i], 32'h9E3779B9 * (i + 1));

        // R10: sleep drops the output at once, ignores a write, preserves data
        v = '{4'd10, 0,1,1,0,1,0,1,1,4'hF,0,0,0,6'd8,1};
        run_cycle(v, '0);
        #1 sleep = 1'b1;
        #1 check_oe("R10", 1'b0);
        v = '{4'd10, 1,0,1,0,1,0,0,1,4'hF,0,0,1,6'd8,0};
        run_cycle(v, 32'hDEADBEEF);
        v = '{4'd10, 1,1,0,0,1,0,1,1,4'hF,0,0,0,6'd0,0};
        run_cycle(v, '0);                    // R10 still deselected after release
        v = '{4'd10, 0,1,1,0,1,0,1,1,4'hF,0,0,0,6'd8,1};
        run_cycle(v, '0);                    // R10 word 8 unchanged

        // R11: reset during an active read burst
        rst = 1'b1;
        @(posedge clk);
        r_live = 1'b0;
        @(negedge clk);
        check_oe("R11", 1'b0);
        rst = 1'b0;
        v = '{4'd11, 1,1,0,0,1,0,1,1,4'hF,0,0,0,6'd0,0};
        run_cycle(v, '0);                    // R11 no burst resumes

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule